// File: doc/BRIEF.md
# Frequency Sweep Burst Sequencer

This block drives the frequency word of a sweeping tone generator. A start pulse loads a start frequency. The block then steps the frequency by a signed increment through a programmed number of steps. Two profiles are available. A sawtooth runs upward once and stops. A triangle runs upward, reverses at the top step and comes back down to the start value. Each frequency holds for one increment window. The window ends either when an internal interval counter expires or when a rising edge arrives on an asynchronous control pin.

Within a window the amplitude path can run for the whole window or only for a burst at the start of it. During the rest of the window the amplitude path holds midscale. The burst length comes from a programmed count or, in externally stepped mode, from the high time of the control pin. Interval and burst counts use either master clocks or ticks that mark completed output waveform cycles. A sync output marks either the end of the sweep as a level or each step as a fixed four-clock pulse. The sync output and the passed-through waveform MSB each have their own output enable, which a pad uses to tri-state them.

Top module: `sweep_seq`

## Requirements
- R1: After reset `busy_o`, `out_active_o` and `sync_o` are 0 and `freq_o` is 0.
- R2: On the clock edge that samples `start_i` high, `freq_o` becomes `f_start_i` and `busy_o` becomes 1, and a new window 0 begins. A start also restarts a sweep that is already running or finished.
- R3: With `cfg_saw_i`=1 the sweep has N+1 windows, where N is `n_incr_i`. Window k, for k from 0 to N, outputs `f_start_i + k*f_delta_i` modulo 2^FW. After the last window `busy_o` and `out_active_o` drop to 0 and `freq_o` returns to `f_start_i`.
- R4: With `cfg_saw_i`=0 the sweep has 2N+1 windows. Window k outputs `f_start_i + k*f_delta_i` for k up to N, then `f_start_i + (2N-k)*f_delta_i`. After the last window the sweep ends as in R3. With N=0 there is one window.
- R5: With `cfg_cont_i`=1, `out_active_o` is 1 for every cycle of every window while busy.
- R6: With `cfg_cont_i`=0 and internal burst, `out_active_o` is 1 for the first `t_burst_i` counting units of each window and 0 (midscale hold) for the rest. It is 1 for the whole window if `t_burst_i` is at least the window length.
- R7: In internal stepping, a window lasts `t_incr_i` counting units. A counting unit is a master clock, or a `cycle_tick_i` pulse when `cfg_incr_cyc_i`=1. The burst count uses `cycle_tick_i` in the same way when `cfg_burst_cyc_i`=1.
- R8: With `cfg_ext_incr_i`=1, the internal interval counter has no effect. Each rising edge of `ctrl_pin_i`, after a two-flop synchroniser, ends the current window one cycle after the edge is detected.
- R9: With `cfg_cont_i`=0, `cfg_ext_incr_i`=1 and `cfg_ext_burst_i`=1, `out_active_o` follows the synchronised level of `ctrl_pin_i`. In every other configuration `cfg_ext_burst_i` has no effect.
- R10: With `cfg_sync_sel_i`=1, `sync_o` goes high on the cycle the sweep ends and stays high until the next start. It is 0 while busy.
- R11: With `cfg_sync_sel_i`=0, `sync_o` is high for exactly 4 master clocks after each step, including the final step. A step inside an active pulse restarts the 4 clocks.
- R12: `sync_oe_o` equals `cfg_sync_en_i`, `msb_oe_o` equals `cfg_msb_en_i`, and `msb_o` passes `msb_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin a sweep |
| cfg_saw_i | input | 1 | 1 sawtooth, 0 triangle |
| cfg_cont_i | input | 1 | 1 continuous, 0 burst |
| cfg_ext_incr_i | input | 1 | 1 steps from control pin |
| cfg_ext_burst_i | input | 1 | 1 burst follows control pin (burst + external step only) |
| cfg_sync_sel_i | input | 1 | 1 end-of-sweep level, 0 per-step pulse |
| cfg_sync_en_i | input | 1 | sync output enable |
| cfg_msb_en_i | input | 1 | MSB output enable |
| cfg_incr_cyc_i | input | 1 | interval counted in waveform cycles |
| cfg_burst_cyc_i | input | 1 | burst counted in waveform cycles |
| f_start_i | input | FW | start frequency word |
| f_delta_i | input | FW | signed increment (two's complement) |
| n_incr_i | input | CW | number of increments N |
| t_incr_i | input | TW | interval length in units, at least 1 |
| t_burst_i | input | TW | burst length in units, at least 1 |
| cycle_tick_i | input | 1 | one pulse per output waveform cycle |
| ctrl_pin_i | input | 1 | asynchronous control pin |
| msb_i | input | 1 | MSB of amplitude data |
| freq_o | output | FW | current frequency word |
| busy_o | output | 1 | sweep running |
| out_active_o | output | 1 | 1 waveform runs, 0 hold midscale |
| sync_o | output | 1 | sync signal |
| sync_oe_o | output | 1 | sync pad enable |
| msb_o | output | 1 | MSB output |
| msb_oe_o | output | 1 | MSB pad enable |

## Verification
The bench builds the block with FW=12, CW=4 and TW=6. These sizes keep every sweep short enough to compare every cycle against an arithmetic model of window index, profile and burst position. Sweeps cover both profiles, N=0 and N>0, positive and negative increments, and a start value near the top of the 12-bit range so that the frequency wraps. Cycle-tick counting, control-pin stepping and pin-driven bursts are driven by hand so that each window boundary lands on a known cycle.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sweep_st_e;

    localparam int SYNC_CLKS = 4;
endpackage

// File: rtl/sweep_pin_sync.sv
module sweep_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a,
    output logic lvl,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } pin_t;

    pin_t st_d, st_q;

    always_comb begin
        st_d.s1 = pin_a;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.s2;
    assign rise = st_q.s2 & ~st_q.s3;

    // R8: a held-high pin yields a single step request
    p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sweep_timer.sv
module sweep_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          unit,
    input  logic [TW-1:0] limit,
    output logic          hit,
    output logic          done
);
    localparam logic [TW-1:0] ONE = TW'(1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t t_d, t_q;

    assign hit  = unit && (t_q.cnt == limit - ONE);
    assign done = t_q.done;

    always_comb begin
        t_d = t_q;
        if (clr) begin
            t_d.cnt  = '0;
            t_d.done = 1'b0;
        end else if (unit) begin
            t_d.cnt = hit ? '0 : t_q.cnt + ONE;
            if (hit) t_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R6: once the burst has elapsed it stays elapsed until the window restarts
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clr |=> done);
endmodule

// File: rtl/sweep_sync_gen.sv
module sweep_sync_gen
    import sweep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic step,
    input  logic sweep_end,
    input  logic sweep_start,
    output logic sync
);
    localparam int PW = $clog2(SYNC_CLKS + 1);
    localparam logic [PW-1:0] PLOAD = PW'(SYNC_CLKS);

    typedef struct packed {
        logic [PW-1:0] pcnt;
        logic          lvl;
    } sg_t;

    sg_t s_d, s_q;
    logic pulse_on;

    always_comb begin
        s_d = s_q;
        if (step)                s_d.pcnt = PLOAD;
        else if (s_q.pcnt != '0) s_d.pcnt = s_q.pcnt - PW'(1);
        if (sweep_start)         s_d.lvl = 1'b0;
        else if (sweep_end)      s_d.lvl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_on = (s_q.pcnt != '0);
    assign sync     = sel ? s_q.lvl : pulse_on;

    // R11: a pulse lasts at least four clocks
    p_pulse_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_on) |=> pulse_on ##1 pulse_on ##1 pulse_on);
    // R10: end-of-sweep level held until a new start
    p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.lvl && !sweep_start |=> s_q.lvl);
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
    import sweep_pkg::*;
#(
    parameter int FW = 24,
    parameter int CW = 12,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cfg_saw_i,
    input  logic          cfg_cont_i,
    input  logic          cfg_ext_incr_i,
    input  logic          cfg_ext_burst_i,
    input  logic          cfg_sync_sel_i,
    input  logic          cfg_sync_en_i,
    input  logic          cfg_msb_en_i,
    input  logic          cfg_incr_cyc_i,
    input  logic          cfg_burst_cyc_i,
    input  logic [FW-1:0] f_start_i,
    input  logic [FW-1:0] f_delta_i,
    input  logic [CW-1:0] n_incr_i,
    input  logic [TW-1:0] t_incr_i,
    input  logic [TW-1:0] t_burst_i,
    input  logic          cycle_tick_i,
    input  logic          ctrl_pin_i,
    input  logic          msb_i,
    output logic [FW-1:0] freq_o,
    output logic          busy_o,
    output logic          out_active_o,
    output logic          sync_o,
    output logic          sync_oe_o,
    output logic          msb_o,
    output logic          msb_oe_o
);
    localparam logic [CW-1:0] IDX_ONE = CW'(1);

    typedef struct packed {
        sweep_st_e     st;
        logic [FW-1:0] freq;
        logic [CW-1:0] idx;
        logic          dn;
    } seq_t;

    seq_t s_d, s_q;

    logic ctrl_lvl, ctrl_rise;
    logic incr_hit, incr_done_unused;
    logic burst_hit_unused, burst_done;
    logic step, at_top, last, win_clr, burst_ext;
    logic incr_unit, burst_unit;

    assign incr_unit  = cfg_incr_cyc_i  ? cycle_tick_i : 1'b1;
    assign burst_unit = cfg_burst_cyc_i ? cycle_tick_i : 1'b1;

    sweep_pin_sync u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_a (ctrl_pin_i),
        .lvl   (ctrl_lvl),
        .rise  (ctrl_rise)
    );

    sweep_timer #(.TW(TW)) u_incr_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .unit  (incr_unit),
        .limit (t_incr_i),
        .hit   (incr_hit),
        .done  (incr_done_unused)
    );

    sweep_timer #(.TW(TW)) u_burst_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .unit  (burst_unit),
        .limit (t_burst_i),
        .hit   (burst_hit_unused),
        .done  (burst_done)
    );

    assign busy_o  = (s_q.st == ST_RUN);
    assign step    = busy_o && (cfg_ext_incr_i ? ctrl_rise : incr_hit);
    assign win_clr = start_i | step;
    assign at_top  = (s_q.idx >= n_incr_i);
    assign last    = s_q.dn ? (s_q.idx == '0)
                            : (at_top && (cfg_saw_i || n_incr_i == '0));

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.st   = ST_RUN;
            s_d.freq = f_start_i;
            s_d.idx  = '0;
            s_d.dn   = 1'b0;
        end else if (step) begin
            if (last) begin
                s_d.st   = ST_DONE;
                s_d.freq = f_start_i;
                s_d.idx  = '0;
                s_d.dn   = 1'b0;
            end else if (!s_q.dn && !at_top) begin
                s_d.idx  = s_q.idx + IDX_ONE;
                s_d.freq = s_q.freq + f_delta_i;
            end else begin
                s_d.dn   = 1'b1;
                s_d.idx  = s_q.idx - IDX_ONE;
                s_d.freq = s_q.freq - f_delta_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, freq: '0, idx: '0, dn: 1'b0};
        else        s_q <= s_d;
    end

    assign burst_ext    = !cfg_cont_i && cfg_ext_incr_i && cfg_ext_burst_i;
    assign out_active_o = busy_o && (cfg_cont_i || (burst_ext ? ctrl_lvl : !burst_done));
    assign freq_o       = s_q.freq;

    sweep_sync_gen u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (cfg_sync_sel_i),
        .step        (step),
        .sweep_end   (step && last),
        .sweep_start (start_i),
        .sync        (sync_o)
    );

    assign sync_oe_o = cfg_sync_en_i;
    assign msb_o     = msb_i;
    assign msb_oe_o  = cfg_msb_en_i;

    // R3: the frequency word moves only on a step or a start
    p_freq_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) && !$past(step) && !$past(start_i) |-> $stable(freq_o));
    // R10: no end-of-sweep level while a sweep runs
    p_busy_no_eos_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && cfg_sync_sel_i |-> !sync_o);
    // R8: in external stepping the interval counter never ends a window
    p_ext_ignores_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && cfg_ext_incr_i && !ctrl_rise && !start_i |=> $stable(freq_o));
endmodule

// File: tb/sweep_seq_bench.sv
module sweep_seq_bench;
    localparam int FW = 12, CW = 4, TW = 6;
    localparam int MASK = (1 << FW) - 1;

    logic clk = 0, rst_n = 0, start_i = 0;
    logic saw = 0, cont = 1, ext_incr = 0, ext_burst = 0, sync_sel = 1;
    logic sync_en = 0, msb_en = 0, incr_cyc = 0, burst_cyc = 0;
    logic [FW-1:0] f_start = 0, f_delta = 0;
    logic [CW-1:0] n_incr = 0;
    logic [TW-1:0] t_incr = 1, t_burst = 1;
    logic tick = 0, ctrl = 0, msb_in = 0;
    logic [FW-1:0] freq;
    logic busy, active, sync, sync_oe, msb, msb_oe;
    int total = 0, fails = 0;

    always #2.5 clk = ~clk;

    sweep_seq #(.FW(FW), .CW(CW), .TW(TW)) u_sweep_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_saw_i(saw), .cfg_cont_i(cont), .cfg_ext_incr_i(ext_incr),
        .cfg_ext_burst_i(ext_burst), .cfg_sync_sel_i(sync_sel),
        .cfg_sync_en_i(sync_en), .cfg_msb_en_i(msb_en),
        .cfg_incr_cyc_i(incr_cyc), .cfg_burst_cyc_i(burst_cyc),
        .f_start_i(f_start), .f_delta_i(f_delta), .n_incr_i(n_incr),
        .t_incr_i(t_incr), .t_burst_i(t_burst), .cycle_tick_i(tick),
        .ctrl_pin_i(ctrl), .msb_i(msb_in), .freq_o(freq), .busy_o(busy),
        .out_active_o(active), .sync_o(sync), .sync_oe_o(sync_oe),
        .msb_o(msb), .msb_oe_o(msb_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // leaves the bench at the negedge after the start edge (cycle 0)
    task automatic do_start();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
    endtask

    task automatic run_sweep(input bit s, input bit c, input int n, input int t,
                             input int b, input int fs, input int d, input bit sel,
                             input bit eb, input bit pin);
        int w_tot = s ? n + 1 : 2 * n + 1;
        saw = s; cont = c; n_incr = CW'(n); t_incr = TW'(t); t_burst = TW'(b);
        f_start = FW'(fs); f_delta = FW'(d); sync_sel = sel;
        ext_incr = 0; ext_burst = eb; ctrl = pin; incr_cyc = 0; burst_cyc = 0;
        repeat (4) @(negedge clk);
        do_start();
        for (int cy = 0; cy < w_tot * t + 6; cy++) begin
            int w = cy / t;
            if (cy < w_tot * t) begin
                int k = (w <= n) ? w : 2 * n - w;
                chk(cy == 0 ? "R2" : "R2 busy", int'(busy), 1);
                chk(s ? "R3" : "R4", int'(freq), (fs + k * d) & MASK);
                chk(eb ? "R9" : (c ? "R5" : "R6"), int'(active),
                    (c || (cy % t) < b) ? 1 : 0);
            end else begin
                chk(s ? "R3 end" : "R4 end", int'(busy), 0);
                chk("R3 end active", int'(active), 0);
                chk("R3 end freq", int'(freq), fs & MASK);
            end
            if (sel) chk("R10", int'(sync), (cy >= w_tot * t) ? 1 : 0);
            else     chk("R11", int'(sync),
                         (cy >= t && (cy % t) < 4 && cy < w_tot * t + 4) ? 1 : 0);
            @(negedge clk);
        end
        ctrl = 0; ext_burst = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 active", int'(active), 0);
        chk("R1 sync", int'(sync), 0);
        chk("R1 freq", int'(freq), 0);

        // R12 enables and MSB pass-through
        for (int m = 0; m < 8; m++) begin
            sync_en = m[0]; msb_en = m[1]; msb_in = m[2];
            @(negedge clk);
            chk("R12 sync_oe", int'(sync_oe), m[0]);
            chk("R12 msb_oe", int'(msb_oe), m[1]);
            chk("R12 msb", int'(msb), m[2]);
        end

        run_sweep(1, 0, 3, 5, 2, 16, 7, 1, 0, 0);    // saw, burst, level sync
        run_sweep(0, 1, 3, 4, 1, 200, -5, 0, 0, 0);  // triangle, negative step, pulses
        run_sweep(0, 0, 0, 5, 3, 9, 4, 1, 0, 0);     // triangle N=0
        run_sweep(1, 1, 0, 4, 1, 33, 2, 0, 0, 0);    // saw N=0
        run_sweep(0, 0, 2, 6, 6, 4090, 3, 0, 0, 0);  // wrap, burst fills window
        run_sweep(1, 0, 2, 6, 3, 50, 1, 1, 1, 1);    // R9: ext burst bit ignored

        // R7: counting in waveform cycles
        saw = 1; cont = 0; n_incr = 1; t_incr = 2; t_burst = 1;
        incr_cyc = 1; burst_cyc = 1; f_start = 100; f_delta = 10; sync_sel = 1;
        do_start();
        for (int i = 0; i < 10; i++) begin
            chk("R7 hold freq", int'(freq), 100);
            chk("R7 burst open", int'(active), 1);
            @(negedge clk);
        end
        tick = 1; @(negedge clk); tick = 0;
        chk("R7 burst after tick", int'(active), 0);
        chk("R7 no step yet", int'(freq), 100);
        repeat (5) @(negedge clk);
        chk("R7 still no step", int'(freq), 100);
        tick = 1; @(negedge clk); tick = 0;
        chk("R7 step on 2nd tick", int'(freq), 110);
        chk("R7 new burst", int'(active), 1);
        incr_cyc = 0; burst_cyc = 0;

        // R8 / R9: stepping and burst from the control pin
        saw = 1; cont = 0; ext_incr = 1; ext_burst = 1; n_incr = 2; t_incr = 2;
        f_start = 300; f_delta = 20; ctrl = 0; sync_sel = 1;
        repeat (4) @(negedge clk);
        do_start();
        for (int i = 0; i < 10; i++) begin
            chk("R8 timer ignored", int'(freq), 300);
            chk("R9 pin low", int'(active), 0);
            @(negedge clk);
        end
        for (int e = 1; e <= 2; e++) begin
            ctrl = 1;
            repeat (4) @(negedge clk);
            chk("R8 step", int'(freq), (300 + 20 * e) & MASK);
            chk("R9 pin high", int'(active), 1);
            repeat (3) @(negedge clk);
            chk("R8 single step", int'(freq), (300 + 20 * e) & MASK);
            ctrl = 0;
            repeat (4) @(negedge clk);
            chk("R9 pin low again", int'(active), 0);
        end
        ctrl = 1;
        repeat (4) @(negedge clk);
        chk("R8 end busy", int'(busy), 0);
        chk("R10 end level", int'(sync), 1);
        ctrl = 0;
        repeat (3) @(negedge clk);
        do_start();
        chk("R10 cleared by start", int'(sync), 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule